// File: doc/BRIEF.md
# Windowed Register Access Sequencer

This block sits on the requesting side of a narrow memory aperture. It turns 32-bit register reads and writes aimed at a wide device address space into accesses on that aperture. The low half of the aperture maps straight onto the first part of the device space. The upper half is a movable window, and its position is set by writing a control word to a fixed aperture location. The sequencer keeps a shadow of the window it last programmed. When a request needs the window moved, it issues the control write first. When the window is already in place, that write is left out.

Two client ports, each with a valid/ready handshake, share the single aperture port. A round-robin arbiter grants one request at a time, and the grant stays with that client until its data access has completed. So a window move and the data access that depends on it can never be split by another client's traffic. Each completed request returns a one-cycle response pulse to its owner, together with the read data when the request was a read.

Top module: `winseq_top`

## Requirements
- R1: A request whose logical offset is below 0x80000, or any request accepted while `win_en` is low, produces exactly one aperture access. That access goes to the low 20 bits of the offset and is not preceded by a window write.
- R2: For any other request, the window number is offset bits [24:19], and the data access goes to aperture address 0x80000 | offset[18:0].
- R3: When a windowed request's window differs from the shadow, the data access is preceded by a write of 0x80000000 | window to aperture address 0x0310C, and the shadow takes that window.
- R4: A windowed request whose window equals the shadow issues no window write. Direct requests leave the shadow unchanged.
- R5: After reset the shadow is invalid, so the first windowed request always issues a window write.
- R6: A window write is immediately followed by its data access, with no other aperture access in between. The aperture request holds its address, direction and data stable until `ap_ready` is seen.
- R7: At most one client is granted at a time. When both clients are pending, the one not served most recently goes first. After reset client 0 has priority.
- R8: One cycle after the data handshake, `rsp_valid` pulses for exactly one cycle on the owner's bit. For a read, `rsp_rdata` carries the `ap_rdata` value sampled at that handshake.
- R9: While reset is asserted, and afterwards with no requests pending, `ap_valid`, `rsp_valid` and `req_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Windowing enable, sampled when a request is accepted |
| req_valid | input | N_CLI | Per-client request valid |
| req_ready | output | N_CLI | Per-client request accept (grant) |
| req_write | input | N_CLI | Per-client direction, 1 = write |
| req_addr | input | N_CLI*LA_W | Per-client logical byte offset |
| req_wdata | input | N_CLI*DW | Per-client write data |
| rsp_valid | output | N_CLI | Per-client completion pulse |
| rsp_rdata | output | DW | Read data of the completed request |
| ap_valid | output | 1 | Aperture access request |
| ap_ready | input | 1 | Aperture access accepted this cycle |
| ap_write | output | 1 | Aperture direction, 1 = write |
| ap_addr | output | AP_W | Aperture address |
| ap_wdata | output | DW | Aperture write data |
| ap_rdata | input | DW | Aperture read data, valid in the handshake cycle |

## Verification
The assertions assume that a client holds its request fields steady while its valid is high and not yet accepted. They also assume the aperture returns read data in the same cycle it raises `ap_ready`. The bench meets both conditions. It changes request fields only outside the window between raising valid and seeing `req_ready`, and its aperture model drives `ap_rdata` combinationally from `ap_addr`. `ap_ready` stalls at random, which exercises the hold rule. Offsets are drawn from a mix of direct-range values, two recurring windows and the full space. That mix is what makes both shadow hits and shadow misses occur.

// File: rtl/winseq_pkg.sv
package winseq_pkg;
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_SEL  = 2'd1,
      WS_DATA = 2'd2
   } ws_state_e;
endpackage

// File: rtl/winseq_rr_arb.sv
module winseq_rr_arb #(
   parameter int N_CLI = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CLI-1:0] req,
   input  logic             adv,
   output logic [N_CLI-1:0] gnt
);
   localparam int IW = (N_CLI > 1) ? $clog2(N_CLI) : 1;

   if (N_CLI < 2) begin : g_bad_ncli
      $error("winseq_rr_arb needs at least two clients");
   end

   logic [IW-1:0] last_q;
   logic          found;

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      for (int i = 0; i < N_CLI; i++) begin
         if (!found && req[(int'(last_q) + 1 + i) % N_CLI]) begin
            gnt[(int'(last_q) + 1 + i) % N_CLI] = 1'b1;
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= IW'(N_CLI - 1);
      end else if (adv) begin
         for (int i = 0; i < N_CLI; i++) begin
            if (gnt[i]) last_q <= IW'(i);
         end
      end
   end

   // R7: never more than one grant
   p_onehot_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R7: a grant only goes to a requester
   p_gnt_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/winseq_xlate.sv
module winseq_xlate #(
   parameter int LA_W      = 25,
   parameter int AP_W      = 20,
   parameter int WIN_SHIFT = 19,
   parameter int WIN_W     = 6
) (
   input  logic [LA_W-1:0]  addr,
   input  logic             en,
   output logic             direct,
   output logic [WIN_W-1:0] win,
   output logic [AP_W-1:0]  ap_addr
);
   if (LA_W != WIN_SHIFT + WIN_W) begin : g_bad_la
      $error("logical width must equal window shift plus window width");
   end
   if (AP_W != WIN_SHIFT + 1) begin : g_bad_ap
      $error("aperture must be two window spans wide");
   end

   assign direct  = !en || (addr[LA_W-1:WIN_SHIFT] == '0);
   assign win     = addr[WIN_SHIFT +: WIN_W];
   assign ap_addr = direct ? addr[AP_W-1:0] : {1'b1, addr[WIN_SHIFT-1:0]};
endmodule

// File: rtl/winseq_top.sv
module winseq_top
   import winseq_pkg::*;
#(
   parameter int          N_CLI     = 2,
   parameter int          LA_W      = 25,
   parameter int          AP_W      = 20,
   parameter int          WIN_SHIFT = 19,
   parameter int          WIN_W     = 6,
   parameter int          DW        = 32,
   parameter logic [19:0] SEL_OFF   = 20'h0310C,
   parameter int          EN_BIT    = 31
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  win_en,
   input  logic [N_CLI-1:0]      req_valid,
   output logic [N_CLI-1:0]      req_ready,
   input  logic [N_CLI-1:0]      req_write,
   input  logic [N_CLI*LA_W-1:0] req_addr,
   input  logic [N_CLI*DW-1:0]   req_wdata,
   output logic [N_CLI-1:0]      rsp_valid,
   output logic [DW-1:0]         rsp_rdata,
   output logic                  ap_valid,
   input  logic                  ap_ready,
   output logic                  ap_write,
   output logic [AP_W-1:0]       ap_addr,
   output logic [DW-1:0]         ap_wdata,
   input  logic [DW-1:0]         ap_rdata
);
   localparam int            IW      = (N_CLI > 1) ? $clog2(N_CLI) : 1;
   localparam logic [DW-1:0] EN_MASK = DW'(1) << EN_BIT;

   if (EN_BIT >= DW || WIN_W >= EN_BIT) begin : g_bad_en
      $error("enable bit must sit above the window field inside the data word");
   end

   ws_state_e        st;
   logic [N_CLI-1:0] gnt;
   logic             accept;
   logic [IW-1:0]    gidx, own_q;
   logic [LA_W-1:0]  g_addr;
   logic [DW-1:0]    g_wdata;
   logic             g_we;
   logic             x_direct;
   logic [WIN_W-1:0] x_win;
   logic [AP_W-1:0]  x_ap;
   logic             need_sel;
   logic             we_q;
   logic [DW-1:0]    wd_q;
   logic [AP_W-1:0]  da_q;
   logic [WIN_W-1:0] win_q, cache_w;
   logic             cache_v;

   winseq_rr_arb #(.N_CLI(N_CLI)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_valid), .adv(accept), .gnt(gnt)
   );

   assign req_ready = (st == WS_IDLE) ? gnt : '0;
   assign accept    = |req_ready;

   always_comb begin
      gidx    = '0;
      g_addr  = '0;
      g_wdata = '0;
      g_we    = 1'b0;
      for (int i = 0; i < N_CLI; i++) begin
         if (gnt[i]) begin
            gidx    = IW'(i);
            g_addr  = req_addr[i*LA_W +: LA_W];
            g_wdata = req_wdata[i*DW +: DW];
            g_we    = req_write[i];
         end
      end
   end

   winseq_xlate #(
      .LA_W(LA_W), .AP_W(AP_W), .WIN_SHIFT(WIN_SHIFT), .WIN_W(WIN_W)
   ) u_xlate (
      .addr(g_addr), .en(win_en), .direct(x_direct), .win(x_win), .ap_addr(x_ap)
   );

   assign need_sel = !x_direct && (!cache_v || (cache_w != x_win));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= WS_IDLE;
         own_q     <= '0;
         we_q      <= 1'b0;
         wd_q      <= '0;
         da_q      <= '0;
         win_q     <= '0;
         cache_v   <= 1'b0;
         cache_w   <= '0;
         rsp_valid <= '0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= '0;
         case (st)
            WS_IDLE: if (accept) begin
               own_q <= gidx;
               we_q  <= g_we;
               wd_q  <= g_wdata;
               da_q  <= x_ap;
               win_q <= x_win;
               st    <= need_sel ? WS_SEL : WS_DATA;
            end
            WS_SEL: if (ap_ready) begin
               cache_v <= 1'b1;
               cache_w <= win_q;
               st      <= WS_DATA;
            end
            WS_DATA: if (ap_ready) begin
               if (!we_q) rsp_rdata <= ap_rdata;
               rsp_valid[own_q] <= 1'b1;
               st               <= WS_IDLE;
            end
            default: st <= WS_IDLE;
         endcase
      end
   end

   assign ap_valid = (st != WS_IDLE);
   assign ap_write = (st == WS_SEL) || we_q;
   assign ap_addr  = (st == WS_SEL) ? SEL_OFF[AP_W-1:0] : da_q;
   assign ap_wdata = (st == WS_SEL) ? (EN_MASK | DW'(win_q)) : wd_q;

   // R6: a stalled aperture request keeps its fields
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_valid && !ap_ready) |=> (ap_valid && $stable(ap_addr)
                                   && $stable(ap_write) && $stable(ap_wdata)));
   // R6: the data access follows the window write at once
   p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_SEL && ap_ready) |=> (st == WS_DATA && ap_valid));
   // R5: invalid shadow forces a window write
   p_first_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !x_direct && !cache_v) |=> (st == WS_SEL));
   // R4: direct requests never move the shadow
   p_direct_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && x_direct) |=> $stable(cache_w) && $stable(cache_v));
   // R8: at most one completion pulse, only after a data handshake
   p_rsp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid));
   p_rsp_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_DATA && ap_ready) |=> (|rsp_valid));
   // R7: no new grant while an access is in flight
   p_no_grant_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ap_valid |-> (req_ready == '0));
endmodule

// File: tb/tb_winseq_top.sv
module tb_winseq_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_en = 1'b1;
   logic [1:0]  req_valid = '0, req_ready, req_write = '0, rsp_valid;
   logic [49:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [31:0] rsp_rdata, ap_wdata, ap_rdata;
   logic        ap_valid, ap_write;
   logic        ap_ready = 1'b0;
   logic [19:0] ap_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   winseq_top dut (
      .clk(clk), .rst_n(rst_n), .win_en(win_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ap_valid(ap_valid), .ap_ready(ap_ready), .ap_write(ap_write),
      .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata)
   );

   function automatic logic [31:0] rd_fn(input logic [19:0] a);
      return 32'h5A00_0000 ^ ({12'h0, a} * 32'd3);
   endfunction
   assign ap_rdata = rd_fn(ap_addr);

   int vec = 0, err = 0;
   bit done = 0;
   logic [19:0] la[0:63];
   logic        lw[0:63];
   logic [31:0] ld[0:63];
   int          ln = 0;
   int          rsp_cnt[0:1] = '{0, 0};
   logic [31:0] rsp_dat[0:1];
   int          first_rsp = -1;
   int          last_served = 1;
   bit          m_v = 0;
   logic [5:0]  m_w = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (!ok) begin
         err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      if (ap_valid && ap_ready) begin
         if (ln < 64) begin
            la[ln] = ap_addr;
            lw[ln] = ap_write;
            ld[ln] = ap_write ? ap_wdata : ap_rdata;
         end
         ln++;
      end
      for (int c = 0; c < 2; c++) begin
         if (rsp_valid[c]) begin
            rsp_cnt[c]++;
            rsp_dat[c] = rsp_rdata;
            if (first_rsp < 0) first_rsp = c;
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      forever begin
         @(posedge clk);
         #1;
         ap_ready = ($urandom % 10) < 7;
      end
   end

   task automatic issue(input int c, input bit we, input logic [24:0] a, input logic [31:0] wd);
      req_write[c] = we;
      req_addr[c*25 +: 25] = a;
      req_wdata[c*32 +: 32] = wd;
      req_valid[c] = 1'b1;
      @(negedge clk);
      while (!req_ready[c]) @(negedge clk);
      @(posedge clk);
      #1;
      req_valid[c] = 1'b0;
   endtask

   task automatic wait_rsp(input int c, input int n);
      while (rsp_cnt[c] < n) @(negedge clk);
   endtask

   task automatic check_op(input int c, input bit we, input logic [24:0] a,
                           input logic [31:0] wd, input bit en, inout int base);
      bit direct;
      logic [19:0] da;
      logic [5:0] w;
      direct = !en || (a < 25'h80000);
      da = direct ? a[19:0] : {1'b1, a[18:0]};
      w = a[24:19];
      if (!direct && (!m_v || w != m_w)) begin
         chk(base < ln && la[base] == 20'h0310C && lw[base], "R3 window write address",
             {12'h0, la[base]}, 32'h0310C);
         chk(ld[base] == (32'h8000_0000 | {26'h0, w}), "R3 window write data",
             ld[base], 32'h8000_0000 | {26'h0, w});
         base++;
         m_v = 1;
         m_w = w;
      end
      chk(base < ln && la[base] == da, direct ? "R1 direct address" : "R2 windowed address",
          {12'h0, la[base]}, {12'h0, da});
      chk(lw[base] == we, "R6 data access direction", {31'h0, lw[base]}, {31'h0, we});
      if (we) chk(ld[base] == wd, "R6 data write value", ld[base], wd);
      else chk(rsp_dat[c] == rd_fn(da), "R8 read data", rsp_dat[c], rd_fn(da));
      base++;
   endtask

   task automatic run(input int c, input bit we, input logic [24:0] a, input logic [31:0] wd, input bit en);
      int base;
      int n0;
      @(posedge clk);
      #1;
      ln = 0;
      base = 0;
      n0 = rsp_cnt[c];
      win_en = en;
      issue(c, we, a, wd);
      wait_rsp(c, n0 + 1);
      @(negedge clk);
      check_op(c, we, a, wd, en, base);
      chk(ln == base, "R4 aperture access count", ln, base);
      chk(rsp_cnt[c] == n0 + 1, "R8 single response pulse", rsp_cnt[c], n0 + 1);
      last_served = c;
   endtask

   task automatic run_pair(input bit we0, input logic [24:0] a0, input bit we1, input logic [24:0] a1);
      int base;
      int n0, n1, f;
      @(posedge clk);
      #1;
      ln = 0;
      base = 0;
      first_rsp = -1;
      win_en = 1'b1;
      n0 = rsp_cnt[0];
      n1 = rsp_cnt[1];
      fork
         issue(0, we0, a0, 32'hC0DE_0000);
         issue(1, we1, a1, 32'hC0DE_0001);
      join
      wait_rsp(0, n0 + 1);
      wait_rsp(1, n1 + 1);
      @(negedge clk);
      f = 1 - last_served;
      chk(first_rsp == f, "R7 round robin order", first_rsp, f);
      if (f == 0) begin
         check_op(0, we0, a0, 32'hC0DE_0000, 1'b1, base);
         check_op(1, we1, a1, 32'hC0DE_0001, 1'b1, base);
      end else begin
         check_op(1, we1, a1, 32'hC0DE_0001, 1'b1, base);
         check_op(0, we0, a0, 32'hC0DE_0000, 1'b1, base);
      end
      chk(ln == base, "R6 paired access count", ln, base);
      last_served = 1 - f;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         err++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vec, err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ap_valid == 0, "R9 reset ap_valid", {31'h0, ap_valid}, 0);
      chk(rsp_valid == 0, "R9 reset rsp_valid", {30'h0, rsp_valid}, 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 0 && ap_valid == 0, "R9 idle outputs", {30'h0, req_ready}, 0);

      run(0, 1'b0, 25'h0000123, 32'h0, 1'b1);          // R1 direct, shadow still invalid
      run(1, 1'b1, 25'h0100ABC, 32'hDEAD_BEEF, 1'b1);  // R5 first windowed access
      run(0, 1'b0, 25'h0104000, 32'h0, 1'b1);          // R4 shadow hit
      run(1, 1'b0, 25'h1F00000, 32'h0, 1'b0);          // R1 windowing off
      run(0, 1'b1, 25'h0107FFF, 32'h1111_2222, 1'b1);  // R4 shadow kept
      run(0, 1'b0, 25'h007FFFF, 32'h0, 1'b1);          // R1 top of direct range
      run(1, 1'b0, 25'h0080000, 32'h0, 1'b1);          // R2 window 1 base
      run(0, 1'b1, 25'h1FFFFFF, 32'h3333_4444, 1'b1);  // R2 last window
      run_pair(1'b0, 25'h0280010, 1'b1, 25'h0300020);  // R7 contention
      run_pair(1'b1, 25'h0300040, 1'b0, 25'h0300080);

      for (int i = 0; i < 60; i++) begin
         int c, m;
         logic [24:0] a;
         c = $urandom % 2;
         m = $urandom % 3;
         if (m == 0) a = 25'($urandom % 32'h80000);
         else if (m == 1) a = {6'(1 + $urandom % 2), 19'($urandom)};
         else a = 25'($urandom);
         if (i % 6 == 5)
            run_pair(1'($urandom), {6'(1 + $urandom % 3), 19'($urandom)},
                     1'($urandom), {6'(1 + $urandom % 3), 19'($urandom)});
         else
            run(c, 1'($urandom), a, $urandom, ($urandom % 4) != 0);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
   end
endmodule